// File: doc/BRIEF.md
# Peripheral Port Register Bank

This block is the register file that sits between a small processor's I/O address space and the chip's general-purpose pins, a DAC and the interrupt unit. The processor writes a register by raising a write strobe with an address and a 16-bit value, and reads one by raising a read strobe. The block keeps the register contents and drives them onto its outputs.

There are five bidirectional 8-bit pin groups. Each group has a value register and a direction register. There is also an 8-bit group that can only be read, a 16-bit output group, a 16-bit DAC sample word that can only be written, a 4-bit DAC setting, a 16-bit interrupt and general control word, and an 8-bit interrupt flag byte. The registers have different widths. A write takes only as many low bits as the register holds. A read always comes back right-justified with zeros above.

The reset input is asynchronous when asserted and is released through an internal two-stage synchronizer, so the first access that takes effect comes on the third rising edge after `rst_n` rises. The flag byte has no reset term and keeps its contents across a reset. The group value registers are also left untouched by reset.

Top module: `io_port_bank`

## Requirements
- R1: A write takes the low bits of `io_wdata` up to the register's width (8 bits for groups, flags and the direction registers, 4 bits for the DAC setting, 16 bits for the rest), and the higher bits have no effect.
- R2: A read returns the register value right-justified on `io_rdata`, with every bit above the register's width equal to zero.
- R3: Direction bit k of group n set to 1 drives `gp_pin_oe[8n+k]` high and puts value-register bit k on `gp_pin_out[8n+k]`. A direction bit of 0 holds `gp_pin_oe[8n+k]` low. The value address of group n is 8n and its direction address is 8n+4, for n from 0 to 4.
- R4: A read of a group's value address returns the sampled pin level `gp_pin_in` for the bits set as inputs and the value register for the bits set as outputs. A read of a direction address returns the direction register.
- R5: Address 0x28 returns `in_f_pins` as sampled at the read edge, and a write to 0x28 changes no register and no output.
- R6: A write to 0x30 sets `dac_word`, and a read from 0x30 returns zero.
- R7: After reset, every direction register, `out_g` (0x2C), `dac_word`, `dac_cfg` (0x34) and `irq_gen_ctrl` (0x38) are zero.
- R8: The flag byte at 0x39 drives `irq_flags` and keeps its value through an assertion and release of `rst_n`.
- R9: A read from an address outside the map returns zero, and a write to such an address changes no register and no output.
- R10: `io_rdata` is registered. It carries the read result in the cycle after the edge that sampled `io_rd`, and it is zero in every cycle that does not follow a read. Reads may be issued back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data, right-justified |
| io_rdata | output | 16 | Registered read data |
| gp_pin_in | input | 40 | Sampled levels of the five bidirectional groups |
| gp_pin_out | output | 40 | Output values of the five groups |
| gp_pin_oe | output | 40 | Per-pin output enables of the five groups |
| in_f_pins | input | 8 | Input-only group levels |
| out_g | output | 16 | Output group |
| dac_word | output | 16 | DAC sample word |
| dac_cfg | output | 4 | DAC setting |
| irq_gen_ctrl | output | 16 | Interrupt and general control word |
| irq_flags | output | 8 | Interrupt flag byte |

## Verification
Every stored bit reaches an output port directly. A corrupted direction, output-group, DAC or control bit therefore shows on the pins in the very cycle after the faulty edge. A wrong value register bit shows on `gp_pin_out` as soon as its direction bit is set. A decode or mux error reaches `io_rdata` exactly one cycle after the read strobe, in one of these forms: a wrong register returned, nonzero high bits, a nonzero value from the DAC word or an unmapped address, or leftover data in an idle cycle. A flag byte that is wrongly reset shows on `irq_flags` as soon as reset releases.

// File: rtl/iopb_pkg.sv
package iopb_pkg;
  // Bidirectional groups: value at base + n*stride, direction at +ctrl offset
  localparam int GP_BASE     = 'h00;
  localparam int GP_STRIDE   = 'h08;
  localparam int GP_CTRL_OFS = 'h04;
  // Remaining registers
  localparam int A_IN_F      = 'h28;
  localparam int A_OUT_G     = 'h2C;
  localparam int A_DAC_WORD  = 'h30;
  localparam int A_DAC_CFG   = 'h34;
  localparam int A_IRQ_CTRL  = 'h38;
  localparam int A_IRQ_FLAG  = 'h39;
endpackage

// File: rtl/iopb_rst_sync.sv
module iopb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/iopb_decode.sv
module iopb_decode #(
  parameter int ADDR_W = 8,
  parameter int GP_NUM = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [GP_NUM-1:0] sel_gp_val,
  output logic [GP_NUM-1:0] sel_gp_dir,
  output logic              sel_in_f,
  output logic              sel_out_g,
  output logic              sel_dac_word,
  output logic              sel_dac_cfg,
  output logic              sel_irq_ctrl,
  output logic              sel_irq_flag,
  output logic              sel_mapped
);
  import iopb_pkg::*;

  for (genvar n = 0; n < GP_NUM; n++) begin : g_gp_dec
    assign sel_gp_val[n] = (addr == ADDR_W'(GP_BASE + n * GP_STRIDE));
    assign sel_gp_dir[n] = (addr == ADDR_W'(GP_BASE + n * GP_STRIDE + GP_CTRL_OFS));
  end

  assign sel_in_f     = (addr == ADDR_W'(A_IN_F));
  assign sel_out_g    = (addr == ADDR_W'(A_OUT_G));
  assign sel_dac_word = (addr == ADDR_W'(A_DAC_WORD));
  assign sel_dac_cfg  = (addr == ADDR_W'(A_DAC_CFG));
  assign sel_irq_ctrl = (addr == ADDR_W'(A_IRQ_CTRL));
  assign sel_irq_flag = (addr == ADDR_W'(A_IRQ_FLAG));

  assign sel_mapped = (|sel_gp_val) | (|sel_gp_dir) | sel_in_f | sel_out_g |
                      sel_dac_word | sel_dac_cfg | sel_irq_ctrl | sel_irq_flag;

  // R9: at most one register selected for any address
  always_comb begin
    sel_unique_chk: assert ($onehot0({sel_gp_val, sel_gp_dir, sel_in_f, sel_out_g,
                                      sel_dac_word, sel_dac_cfg, sel_irq_ctrl,
                                      sel_irq_flag}));
  end
endmodule

// File: rtl/iopb_gpio_port.sv
module iopb_gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         val_we,
  input  logic         dir_we,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val,
  output logic [W-1:0] rd_dir
);
  logic [W-1:0] val_q, val_d;
  logic [W-1:0] dir_q, dir_d;

  always_comb begin
    val_d = val_q;
    if (val_we) val_d = wr_val;
    dir_d = dir_q;
    if (dir_we) dir_d = wr_val;
  end

  // Value register carries no reset term
  always_ff @(posedge clk) begin
    val_q <= val_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else        dir_q <= dir_d;
  end

  assign pin_out = val_q;
  assign pin_oe  = dir_q;
  assign rd_val  = (pin_in & ~dir_q) | (val_q & dir_q);
  assign rd_dir  = dir_q;

  // R3
  dir_write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> (pin_oe == $past(wr_val)));

  // R3
  dir_hold_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(pin_oe));
endmodule

// File: rtl/iopb_reg.sv
module iopb_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = q;
    if (we) d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/io_port_bank.sv
module io_port_bank #(
  parameter int ADDR_W   = 8,
  parameter int BUS_W    = 16,
  parameter int GP_NUM   = 5,
  parameter int GP_W     = 8,
  parameter int IN_W     = 8,
  parameter int DACCFG_W = 4,
  parameter int FLAG_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic [BUS_W-1:0]       io_wdata,
  output logic [BUS_W-1:0]       io_rdata,
  input  logic [GP_NUM*GP_W-1:0] gp_pin_in,
  output logic [GP_NUM*GP_W-1:0] gp_pin_out,
  output logic [GP_NUM*GP_W-1:0] gp_pin_oe,
  input  logic [IN_W-1:0]        in_f_pins,
  output logic [BUS_W-1:0]       out_g,
  output logic [BUS_W-1:0]       dac_word,
  output logic [DACCFG_W-1:0]    dac_cfg,
  output logic [BUS_W-1:0]       irq_gen_ctrl,
  output logic [FLAG_W-1:0]      irq_flags
);
  logic rst_sync_n;
  logic wr_ok;

  logic [GP_NUM-1:0] sel_gp_val, sel_gp_dir;
  logic sel_in_f, sel_out_g, sel_dac_word, sel_dac_cfg;
  logic sel_irq_ctrl, sel_irq_flag, sel_mapped;

  logic [GP_W-1:0] gp_rd_val [GP_NUM];
  logic [GP_W-1:0] gp_rd_dir [GP_NUM];

  logic [FLAG_W-1:0] flag_q, flag_d;
  logic [BUS_W-1:0]  rd_mux;
  logic [BUS_W-1:0]  rdata_d;

  iopb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  iopb_decode #(.ADDR_W(ADDR_W), .GP_NUM(GP_NUM)) u_decode (
    .addr         (io_addr),
    .sel_gp_val   (sel_gp_val),
    .sel_gp_dir   (sel_gp_dir),
    .sel_in_f     (sel_in_f),
    .sel_out_g    (sel_out_g),
    .sel_dac_word (sel_dac_word),
    .sel_dac_cfg  (sel_dac_cfg),
    .sel_irq_ctrl (sel_irq_ctrl),
    .sel_irq_flag (sel_irq_flag),
    .sel_mapped   (sel_mapped)
  );

  // Writes are blocked while the synchronized reset is held
  assign wr_ok = io_wr & rst_sync_n;

  for (genvar n = 0; n < GP_NUM; n++) begin : g_gp
    iopb_gpio_port #(.W(GP_W)) u_port (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .val_we  (wr_ok & sel_gp_val[n]),
      .dir_we  (wr_ok & sel_gp_dir[n]),
      .wr_val  (io_wdata[GP_W-1:0]),
      .pin_in  (gp_pin_in[n*GP_W +: GP_W]),
      .pin_out (gp_pin_out[n*GP_W +: GP_W]),
      .pin_oe  (gp_pin_oe[n*GP_W +: GP_W]),
      .rd_val  (gp_rd_val[n]),
      .rd_dir  (gp_rd_dir[n])
    );
  end

  iopb_reg #(.W(BUS_W)) u_out_g (
    .clk (clk), .rst_n (rst_sync_n), .we (wr_ok & sel_out_g),
    .wr_val (io_wdata), .q (out_g)
  );

  iopb_reg #(.W(BUS_W)) u_dac_word (
    .clk (clk), .rst_n (rst_sync_n), .we (wr_ok & sel_dac_word),
    .wr_val (io_wdata), .q (dac_word)
  );

  iopb_reg #(.W(DACCFG_W)) u_dac_cfg (
    .clk (clk), .rst_n (rst_sync_n), .we (wr_ok & sel_dac_cfg),
    .wr_val (io_wdata[DACCFG_W-1:0]), .q (dac_cfg)
  );

  iopb_reg #(.W(BUS_W)) u_irq_ctrl (
    .clk (clk), .rst_n (rst_sync_n), .we (wr_ok & sel_irq_ctrl),
    .wr_val (io_wdata), .q (irq_gen_ctrl)
  );

  // Flag byte: no reset term, contents survive reset
  always_comb begin
    flag_d = flag_q;
    if (wr_ok && sel_irq_flag) flag_d = io_wdata[FLAG_W-1:0];
  end

  always_ff @(posedge clk) begin
    flag_q <= flag_d;
  end

  assign irq_flags = flag_q;

  // Read selection: unselected sources contribute zero
  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < GP_NUM; n++) begin
      if (sel_gp_val[n]) rd_mux = rd_mux | BUS_W'(gp_rd_val[n]);
      if (sel_gp_dir[n]) rd_mux = rd_mux | BUS_W'(gp_rd_dir[n]);
    end
    if (sel_in_f)     rd_mux = rd_mux | BUS_W'(in_f_pins);
    if (sel_out_g)    rd_mux = rd_mux | out_g;
    if (sel_dac_cfg)  rd_mux = rd_mux | BUS_W'(dac_cfg);
    if (sel_irq_ctrl) rd_mux = rd_mux | irq_gen_ctrl;
    if (sel_irq_flag) rd_mux = rd_mux | BUS_W'(flag_q);
  end

  assign rdata_d = io_rd ? rd_mux : '0;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) io_rdata <= '0;
    else             io_rdata <= rdata_d;
  end

  // R2
  narrow_read_zext_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && ((|sel_gp_val) || (|sel_gp_dir) || sel_in_f || sel_irq_flag))
      |=> (io_rdata[BUS_W-1:GP_W] == '0));

  // R2
  cfg_read_zext_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && sel_dac_cfg) |=> (io_rdata[BUS_W-1:DACCFG_W] == '0));

  // R6
  dac_word_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && sel_dac_word) |=> (io_rdata == '0));

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && !sel_mapped) |=> (io_rdata == '0));

  // R10
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !io_rd |=> (io_rdata == '0));

  // R8
  flag_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr && sel_irq_flag) |=> (irq_flags == $past(io_wdata[FLAG_W-1:0])));
endmodule

// File: tb/io_port_bank_tb_top.sv
module io_port_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic [39:0] gp_pin_in = '0;
  logic [39:0] gp_pin_out, gp_pin_oe;
  logic [7:0]  in_f_pins = '0;
  logic [15:0] out_g, dac_word, irq_gen_ctrl;
  logic [3:0]  dac_cfg;
  logic [7:0]  irq_flags;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  io_port_bank dut_i (
    .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wr (io_wr),
    .io_rd (io_rd), .io_wdata (io_wdata), .io_rdata (io_rdata),
    .gp_pin_in (gp_pin_in), .gp_pin_out (gp_pin_out), .gp_pin_oe (gp_pin_oe),
    .in_f_pins (in_f_pins), .out_g (out_g), .dac_word (dac_word),
    .dac_cfg (dac_cfg), .irq_gen_ctrl (irq_gen_ctrl), .irq_flags (irq_flags)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]  m_val [5];
  logic [7:0]  m_dir [5];
  logic [15:0] m_g, m_dac, m_ctl, m_rd;
  logic [3:0]  m_cfg;
  logic [7:0]  m_flag = 'x;
  int          rel_cnt = 0;
  bit          m_rst = 1'b1;

  function automatic logic [15:0] ref_read(input logic [7:0] a);
    for (int n = 0; n < 5; n++) begin
      if (a == 8'(8 * n))
        return {8'h00, (gp_pin_in[n*8 +: 8] & ~m_dir[n]) | (m_val[n] & m_dir[n])};
      if (a == 8'(8 * n + 4)) return {8'h00, m_dir[n]};
    end
    case (a)
      8'h28:   return {8'h00, in_f_pins};
      8'h2C:   return m_g;
      8'h34:   return {12'h000, m_cfg};
      8'h38:   return m_ctl;
      8'h39:   return {8'h00, m_flag};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic ref_write(input logic [7:0] a, input logic [15:0] d);
    for (int n = 0; n < 5; n++) begin
      if (a == 8'(8 * n))     m_val[n] = d[7:0];
      if (a == 8'(8 * n + 4)) m_dir[n] = d[7:0];
    end
    case (a)
      8'h2C: m_g   = d;
      8'h30: m_dac = d;
      8'h34: m_cfg = d[3:0];
      8'h38: m_ctl = d;
      8'h39: m_flag = d[7:0];
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rel_cnt = 0;
      m_rst = 1'b1;
    end else begin
      m_rst = (rel_cnt < 2);
      if (rel_cnt < 2) rel_cnt++;
    end
    if (m_rst) begin
      for (int n = 0; n < 5; n++) m_dir[n] = 8'h00;
      m_g = '0; m_dac = '0; m_cfg = '0; m_ctl = '0; m_rd = '0;
    end else begin
      m_rd = io_rd ? ref_read(io_addr) : 16'h0000;
      if (io_wr) ref_write(io_addr, io_wdata);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !m_rst) begin
      chk(io_rdata === m_rd, cur_req, 64'(io_rdata), 64'(m_rd));
      for (int n = 0; n < 5; n++) begin
        chk(gp_pin_oe[n*8 +: 8] === m_dir[n], "R3", 64'(gp_pin_oe[n*8 +: 8]), 64'(m_dir[n]));
        chk((gp_pin_out[n*8 +: 8] & m_dir[n]) === (m_val[n] & m_dir[n]), "R3",
            64'(gp_pin_out[n*8 +: 8] & m_dir[n]), 64'(m_val[n] & m_dir[n]));
      end
      chk(out_g === m_g, "R1", 64'(out_g), 64'(m_g));
      chk(dac_word === m_dac, "R6", 64'(dac_word), 64'(m_dac));
      chk(dac_cfg === m_cfg, "R1", 64'(dac_cfg), 64'(m_cfg));
      chk(irq_gen_ctrl === m_ctl, "R1", 64'(irq_gen_ctrl), 64'(m_ctl));
      if (^m_flag !== 1'bx)
        chk(irq_flags === m_flag, "R8", 64'(irq_flags), 64'(m_flag));
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_wr(input logic [7:0] a, input logic [15:0] d, input string req);
    @(negedge clk);
    cur_req = req; io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input string req);
    @(negedge clk);
    cur_req = req; io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic do_rd2(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    cur_req = "R10"; io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_addr = b;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic pulse_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R7: reset state against constants
    chk(gp_pin_oe === 40'h0, "R7", 64'(gp_pin_oe), 64'h0);
    chk(out_g === 16'h0, "R7", 64'(out_g), 64'h0);
    chk(dac_word === 16'h0, "R7", 64'(dac_word), 64'h0);
    chk(dac_cfg === 4'h0, "R7", 64'(dac_cfg), 64'h0);
    chk(irq_gen_ctrl === 16'h0, "R7", 64'(irq_gen_ctrl), 64'h0);
    chk(io_rdata === 16'h0, "R10", 64'(io_rdata), 64'h0);
    do_rd(8'h0C, "R7");

    do_wr(8'h39, 16'hFF5A, "R8");

    // Bidirectional groups: upper write bits ignored, mixed directions
    for (int n = 0; n < 5; n++) begin
      gp_pin_in[n*8 +: 8] = 8'(8'h3C ^ (n * 17));
      do_wr(8'(8 * n), 16'hA500 | 16'(8'hC3 + n), "R1");
      do_rd(8'(8 * n), "R4");
      do_wr(8'(8 * n + 4), 16'hFF00 | 16'(8'h0F << (n % 4)), "R3");
      do_rd(8'(8 * n), "R4");
      do_rd(8'(8 * n + 4), "R2");
      gp_pin_in[n*8 +: 8] = ~gp_pin_in[n*8 +: 8];
      do_rd(8'(8 * n), "R4");
    end
    do_wr(8'h14, 16'h00FF, "R3");
    do_rd(8'h10, "R4");
    do_wr(8'h14, 16'h0000, "R3");
    do_rd(8'h10, "R4");

    // Input-only group
    in_f_pins = 8'h96;
    do_rd(8'h28, "R5");
    do_wr(8'h28, 16'hFFFF, "R5");
    in_f_pins = 8'h41;
    do_rd(8'h28, "R5");

    // Wide registers and DAC
    do_wr(8'h2C, 16'hBEEF, "R1");
    do_rd(8'h2C, "R2");
    do_wr(8'h30, 16'h1234, "R6");
    do_rd(8'h30, "R6");
    do_wr(8'h34, 16'hFFFA, "R1");
    do_rd(8'h34, "R2");
    do_wr(8'h38, 16'h8001, "R1");
    do_rd(8'h38, "R2");
    do_rd(8'h39, "R2");

    // Unmapped addresses
    do_wr(8'h3C, 16'hFFFF, "R9");
    do_wr(8'h01, 16'hFFFF, "R9");
    do_wr(8'h3A, 16'hFFFF, "R9");
    do_rd(8'h3C, "R9");
    do_rd(8'h01, "R9");
    do_rd(8'hFF, "R9");

    // Back-to-back reads
    do_rd2(8'h2C, 8'h38);
    do_rd2(8'h39, 8'h30);
    repeat (2) @(negedge clk);

    // Reset again: flags retained, directions and words cleared
    pulse_reset();
    @(negedge clk);
    chk(irq_flags === 8'h5A, "R8", 64'(irq_flags), 64'h5A);
    chk(gp_pin_oe === 40'h0, "R7", 64'(gp_pin_oe), 64'h0);
    chk(out_g === 16'h0, "R7", 64'(out_g), 64'h0);
    do_rd(8'h39, "R8");
    do_rd(8'h00, "R4");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule